// File: doc/BRIEF.md
# Power Mode Protection Gate

This block holds a small set of permission flags that decide which low-power modes the system may enter, and it tracks the current power mode. Software sets the permissions by writing a byte-wide protection register once after chip reset. After that first write the register is frozen until the next chip reset. A second register carries the run-mode field. Writing that field asks for a switch between normal run and very-low-power run. Separate request pins ask for wait, for one of several stop modes, and for a wake-up.

Every request is checked against the permission flags. A request that is not permitted, or that uses a reserved code, is dropped without any error. In that case both the reported mode and the run-mode field keep their previous values. The permissions live in the chip-reset domain. A warm reset returns the mode to normal run but leaves the permissions, and the once-only lock, unchanged.

Top module: `pmg_top`

## Requirements
- R1: After chip reset, the protection register reads 0x00, the control register reads 0x00, and `power_mode` is 0 (normal run).
- R2: In the protection register only bits 5, 3 and 1 are stored: bit 5 is very-low-power, bit 3 is low-leakage stop, bit 1 is very-low-leakage stop. Bits 7, 6, 4, 2 and 0 always read 0, whatever was written.
- R3: The first write cycle to the protection address (address 0) loads the three permission bits and sets the lock, whatever the data. Every later write to that address has no effect until chip reset.
- R4: A warm reset sets `power_mode` to 0 and the run-mode field to 00. It keeps the permission bits and the lock. Only a chip reset clears them.
- R5: The run-mode field sits in control register (address 1) bits 1:0: 00 is normal run and 10 is very-low-power run. Writing 10 while the very-low-power bit is 0 is blocked and the field stays 00. Writing 01 or 11 is always rejected.
- R6: Writing 00 to the run-mode field from very-low-power run always returns to normal run.
- R7: Stop codes are 000 normal stop, 010 very-low-power stop (needs bit 5), 011 low-leakage stop (needs bit 3) and 100 very-low-leakage stop (needs bit 1). Any other code, or a code whose permission bit is 0, leaves the mode unchanged.
- R8: `power_mode` encodings: 0 run, 1 very-low-power run, 2 wait, 3 very-low-power wait, 4 stop, 5 very-low-power stop, 6 low-leakage stop, 7 very-low-leakage stop. Wait entered from mode 0 gives 2 and from mode 1 gives 3. Normal stop entered from mode 0 gives 4 and from mode 1 gives 5.
- R9: In modes 2 to 7 only a wake request has an effect. Wake returns to the run mode that the run-mode field selects. Stop, wait and run-field requests made while asleep are ignored.
- R10: When several requests arrive in the same cycle, only the highest-priority one present is evaluated, in the order stop, then wait, then run-field write. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| chip_rst_n | input | 1 | Chip reset, active low, synchronous; clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; resets the mode only |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from `bus_addr` |
| stop_req | input | 1 | Stop-mode request strobe |
| stop_code | input | 3 | Requested stop mode |
| wait_req | input | 1 | Wait-mode request strobe |
| wake_req | input | 1 | Wake-up strobe |
| power_mode | output | 3 | Current power mode |

## Verification
The bench first writes a byte that is zero in the permission positions, then tries a second write. This catches a lock that depends on the data written rather than on the write itself. It asks for very-low-power run and for each stop code with its permission bit both clear and set. A gate that ignores the flags would change the mode, and one that accepts reserved codes would move to a stray state. It applies a warm reset while in a deep stop mode and then tries to rewrite the protection register. A design that put the permissions in the warm domain would lose them or reopen the lock. Finally it sends a stop request, a wait request and a run-field write in the same cycle, which exposes a wrong priority order.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    typedef enum logic [2:0] {
        PM_RUN  = 3'd0,
        PM_VLPR = 3'd1,
        PM_WAIT = 3'd2,
        PM_VLPW = 3'd3,
        PM_STOP = 3'd4,
        PM_VLPS = 3'd5,
        PM_LLS  = 3'd6,
        PM_VLLS = 3'd7
    } pmode_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STOP,
        CMD_WAIT,
        CMD_RUN,
        CMD_WAKE
    } cmd_e;

    localparam logic [1:0] RUNF_NORMAL = 2'b00;
    localparam logic [1:0] RUNF_VLP    = 2'b10;

    localparam logic [2:0] STOPC_NORMAL = 3'b000;
    localparam logic [2:0] STOPC_VLPS   = 3'b010;
    localparam logic [2:0] STOPC_LLS    = 3'b011;
    localparam logic [2:0] STOPC_VLLS   = 3'b100;

    localparam int BIT_VLP  = 5;
    localparam int BIT_LLS  = 3;
    localparam int BIT_VLLS = 1;

    typedef struct packed {
        logic vlp;
        logic lls;
        logic vlls;
    } perm_t;

    typedef struct packed {
        pmode_e     mode;
        logic [1:0] run_f;
    } mstate_t;

endpackage

// File: rtl/pmg_perm_reg.sv
module pmg_perm_reg
    import pmg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              chip_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output perm_t             perm,
    output logic              locked,
    output logic [DATA_W-1:0] rd_view
);

    localparam logic [DATA_W-1:0] KEEP_MASK =
        DATA_W'((1 << BIT_VLP) | (1 << BIT_LLS) | (1 << BIT_VLLS));

    typedef struct packed {
        logic [DATA_W-1:0] bits;
        logic              lock;
    } preg_t;

    preg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en && !reg_q.lock) begin
            reg_d.lock = 1'b1;
            reg_d.bits = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!chip_rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign perm.vlp  = reg_q.bits[BIT_VLP];
    assign perm.lls  = reg_q.bits[BIT_LLS];
    assign perm.vlls = reg_q.bits[BIT_VLLS];
    assign locked    = reg_q.lock;
    assign rd_view   = reg_q.bits;

endmodule

// File: rtl/pmg_req_sel.sv
module pmg_req_sel
    import pmg_pkg::*;
(
    input  logic asleep,
    input  logic stop_req,
    input  logic wait_req,
    input  logic run_wr,
    input  logic wake_req,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (asleep) begin
            if (wake_req) begin
                cmd = CMD_WAKE;
            end
        end else if (stop_req) begin
            cmd = CMD_STOP;
        end else if (wait_req) begin
            cmd = CMD_WAIT;
        end else if (run_wr) begin
            cmd = CMD_RUN;
        end
    end

endmodule

// File: rtl/pmg_mode_ctl.sv
module pmg_mode_ctl
    import pmg_pkg::*;
(
    input  logic       clk,
    input  logic       chip_rst_n,
    input  logic       warm_rst_n,
    input  perm_t      perm,
    input  cmd_e       cmd,
    input  logic [2:0] stop_code,
    input  logic [1:0] run_code,
    output mstate_t    state,
    output logic       asleep
);

    mstate_t st_d, st_q;
    logic    in_vlp_run;

    assign in_vlp_run = (st_q.mode == PM_VLPR);
    assign asleep     = (st_q.mode != PM_RUN) && (st_q.mode != PM_VLPR);

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_STOP: begin
                unique case (stop_code)
                    STOPC_NORMAL: st_d.mode = in_vlp_run ? PM_VLPS : PM_STOP;
                    STOPC_VLPS:   if (perm.vlp)  st_d.mode = PM_VLPS;
                    STOPC_LLS:    if (perm.lls)  st_d.mode = PM_LLS;
                    STOPC_VLLS:   if (perm.vlls) st_d.mode = PM_VLLS;
                    default:      st_d = st_q;
                endcase
            end
            CMD_WAIT: begin
                st_d.mode = in_vlp_run ? PM_VLPW : PM_WAIT;
            end
            CMD_RUN: begin
                unique case (run_code)
                    RUNF_NORMAL: begin
                        st_d.mode  = PM_RUN;
                        st_d.run_f = RUNF_NORMAL;
                    end
                    RUNF_VLP: begin
                        if (perm.vlp) begin
                            st_d.mode  = PM_VLPR;
                            st_d.run_f = RUNF_VLP;
                        end
                    end
                    default: st_d = st_q;
                endcase
            end
            CMD_WAKE: begin
                st_d.mode = (st_q.run_f == RUNF_VLP) ? PM_VLPR : PM_RUN;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!chip_rst_n || !warm_rst_n) begin
            st_q <= '{mode: PM_RUN, run_f: RUNF_NORMAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/pmg_top.sv
module pmg_top
    import pmg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int PROT_ADDR = 0,
    parameter int CTRL_ADDR = 1
) (
    input  logic              clk,
    input  logic              chip_rst_n,
    input  logic              warm_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_req,
    input  logic [2:0]        stop_code,
    input  logic              wait_req,
    input  logic              wake_req,
    output logic [2:0]        power_mode
);

    localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic              hit_prot, hit_ctrl;
    logic              prot_wr, ctrl_wr;
    perm_t             perm_s;
    logic              locked;
    logic [DATA_W-1:0] prot_view;
    logic              asleep;
    cmd_e              cmd;
    mstate_t           mstate;
    logic              unused_wdata_hi;

    assign hit_prot = (bus_addr == PROT_A);
    assign hit_ctrl = (bus_addr == CTRL_A);
    assign prot_wr  = bus_we && hit_prot;
    assign ctrl_wr  = bus_we && hit_ctrl;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2];

    pmg_perm_reg #(
        .DATA_W (DATA_W)
    ) u_perm (
        .clk        (clk),
        .chip_rst_n (chip_rst_n),
        .wr_en      (prot_wr),
        .wdata      (bus_wdata),
        .perm       (perm_s),
        .locked     (locked),
        .rd_view    (prot_view)
    );

    pmg_req_sel u_sel (
        .asleep   (asleep),
        .stop_req (stop_req),
        .wait_req (wait_req),
        .run_wr   (ctrl_wr),
        .wake_req (wake_req),
        .cmd      (cmd)
    );

    pmg_mode_ctl u_mode (
        .clk        (clk),
        .chip_rst_n (chip_rst_n),
        .warm_rst_n (warm_rst_n),
        .perm       (perm_s),
        .cmd        (cmd),
        .stop_code  (stop_code),
        .run_code   (bus_wdata[1:0]),
        .state      (mstate),
        .asleep     (asleep)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_prot) begin
            bus_rdata = prot_view;
        end else if (hit_ctrl) begin
            bus_rdata[1:0] = mstate.run_f;
        end
    end

    assign power_mode = mstate.mode;

endmodule

// File: rtl/pmg_checker.sv
module pmg_checker #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int PROT_ADDR = 0,
    parameter int CTRL_ADDR = 1
) (
    input logic              clk,
    input logic              chip_rst_n,
    input logic              warm_rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              stop_req,
    input logic              wait_req,
    input logic [2:0]        power_mode,
    input logic              lock,
    input logic [2:0]        perm_bits
);

    localparam logic [DATA_W-1:0] RSVD = ~DATA_W'((1 << 5) | (1 << 3) | (1 << 1));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!chip_rst_n)
        (bus_addr == ADDR_W'(PROT_ADDR)) |-> ((bus_rdata & RSVD) == '0));

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!chip_rst_n)
        lock |=> lock);

    p_frozen_r3: assert property (@(posedge clk) disable iff (!chip_rst_n)
        lock |=> (perm_bits == $past(perm_bits)));

    p_warm_keeps_r4: assert property (@(posedge clk) disable iff (!chip_rst_n)
        (!warm_rst_n && !bus_we) |=> (perm_bits == $past(perm_bits)) && (lock == $past(lock)));

    p_warm_run_r4: assert property (@(posedge clk) disable iff (!chip_rst_n)
        !warm_rst_n |=> (power_mode == 3'd0));

    p_vlp_gate_r5: assert property (@(posedge clk) disable iff (!chip_rst_n)
        (power_mode == 3'd1 || power_mode == 3'd3 || power_mode == 3'd5) |-> perm_bits[2]);

    p_blocked_vlpr_r5: assert property (@(posedge clk) disable iff (!chip_rst_n || !warm_rst_n)
        (bus_we && bus_addr == ADDR_W'(CTRL_ADDR) && bus_wdata[1:0] == 2'b10 && !perm_bits[2]
         && power_mode == 3'd0 && !stop_req && !wait_req) |=> (power_mode == 3'd0));

    p_reserved_run_r5: assert property (@(posedge clk) disable iff (!chip_rst_n || !warm_rst_n)
        (bus_we && bus_addr == ADDR_W'(CTRL_ADDR) && bus_wdata[0] && power_mode <= 3'd1
         && !stop_req && !wait_req) |=> (power_mode == $past(power_mode)));

    p_lls_gate_r7: assert property (@(posedge clk) disable iff (!chip_rst_n)
        (power_mode == 3'd6) |-> perm_bits[1]);

    p_vlls_gate_r7: assert property (@(posedge clk) disable iff (!chip_rst_n)
        (power_mode == 3'd7) |-> perm_bits[0]);

endmodule

bind pmg_top pmg_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PROT_ADDR (PROT_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk        (clk),
    .chip_rst_n (chip_rst_n),
    .warm_rst_n (warm_rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .stop_req   (stop_req),
    .wait_req   (wait_req),
    .power_mode (power_mode),
    .lock       (locked),
    .perm_bits  (perm_s)
);

// File: tb/tb_pmg_top.sv
module tb_pmg_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       chip_rst_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0;
    logic [2:0] stop_code = '0;
    logic       wait_req = 1'b0;
    logic       wake_req = 1'b0;
    logic [2:0] power_mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pmg_top dut (
        .clk        (clk),
        .chip_rst_n (chip_rst_n),
        .warm_rst_n (warm_rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .stop_req   (stop_req),
        .stop_code  (stop_code),
        .wait_req   (wait_req),
        .wake_req   (wake_req),
        .power_mode (power_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chip_reset();
        @(negedge clk);
        chip_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chip_rst_n = 1'b1;
    endtask

    task automatic cycle(input bit s, input logic [2:0] c, input bit w, input bit k,
                         input bit we, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        stop_req = s; stop_code = c; wait_req = w; wake_req = k;
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        stop_req = 1'b0; wait_req = 1'b0; wake_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cycle(0, 3'd0, 0, 0, 1, a, d);
    endtask

    task automatic stop(input logic [2:0] c);
        cycle(1, c, 0, 0, 0, bus_addr, bus_wdata);
    endtask

    task automatic wake();
        cycle(0, 3'd0, 0, 1, 0, bus_addr, bus_wdata);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chip_reset();
        rd(4'd0, v); chk("R1 prot", v, 8'h00);
        rd(4'd1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 mode", {5'd0, power_mode}, 8'd0);
    endtask

    task automatic t_vlpr_blocked();
        logic [7:0] v;
        wr(4'd1, 8'h02);
        rd(4'd1, v); chk("R5 blocked field", v, 8'h00);
        chk("R5 blocked mode", {5'd0, power_mode}, 8'd0);
        wr(4'd1, 8'h01);
        chk("R5 code01", {5'd0, power_mode}, 8'd0);
        wr(4'd1, 8'h03);
        rd(4'd1, v); chk("R5 code11", v, 8'h00);
    endtask

    task automatic t_write_once();
        logic [7:0] v;
        wr(4'd0, 8'hFF);
        rd(4'd0, v); chk("R2 reserved bits", v, 8'h2A);
        wr(4'd0, 8'h00);
        rd(4'd0, v); chk("R3 second write", v, 8'h2A);
        chip_reset();
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h20);
        rd(4'd0, v); chk("R3 lock by zero write", v, 8'h00);
    endtask

    task automatic t_vlp_modes();
        logic [7:0] v;
        chip_reset();
        wr(4'd0, 8'h20);
        wr(4'd1, 8'h02);
        chk("R5 vlpr entry", {5'd0, power_mode}, 8'd1);
        rd(4'd1, v); chk("R5 field 10", v, 8'h02);
        wr(4'd1, 8'h01);
        chk("R5 reserved in vlpr", {5'd0, power_mode}, 8'd1);
        cycle(0, 3'd0, 1, 0, 0, 4'd1, 8'h00);
        chk("R8 vlp wait", {5'd0, power_mode}, 8'd3);
        wake();
        chk("R9 wake to vlpr", {5'd0, power_mode}, 8'd1);
        stop(3'b000);
        chk("R8 normal stop from vlpr", {5'd0, power_mode}, 8'd5);
        wake();
        chk("R9 wake vlps", {5'd0, power_mode}, 8'd1);
        wr(4'd1, 8'h00);
        chk("R6 back to run", {5'd0, power_mode}, 8'd0);
        stop(3'b000);
        chk("R8 normal stop from run", {5'd0, power_mode}, 8'd4);
        wake();
        cycle(0, 3'd0, 1, 0, 0, 4'd1, 8'h00);
        chk("R8 wait from run", {5'd0, power_mode}, 8'd2);
        stop(3'b010);
        chk("R9 stop ignored asleep", {5'd0, power_mode}, 8'd2);
        wr(4'd1, 8'h02);
        rd(4'd1, v); chk("R9 run write ignored asleep", v, 8'h00);
        wake();
        chk("R9 wake to run", {5'd0, power_mode}, 8'd0);
    endtask

    task automatic t_stop_perm();
        stop(3'b011);
        chk("R7 lls denied", {5'd0, power_mode}, 8'd0);
        stop(3'b100);
        chk("R7 vlls denied", {5'd0, power_mode}, 8'd0);
        stop(3'b101);
        chk("R7 reserved code", {5'd0, power_mode}, 8'd0);
        stop(3'b010);
        chk("R7 vlps allowed", {5'd0, power_mode}, 8'd5);
        wake();
        chk("R9 vlps wake to run", {5'd0, power_mode}, 8'd0);
        chip_reset();
        wr(4'd0, 8'h0A);
        stop(3'b010);
        chk("R7 vlps denied", {5'd0, power_mode}, 8'd0);
        stop(3'b011);
        chk("R7 lls allowed", {5'd0, power_mode}, 8'd6);
        wake();
        stop(3'b100);
        chk("R7 vlls allowed", {5'd0, power_mode}, 8'd7);
    endtask

    task automatic t_warm_reset();
        logic [7:0] v;
        @(negedge clk);
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        chk("R4 warm to run", {5'd0, power_mode}, 8'd0);
        rd(4'd0, v); chk("R4 perms kept", v, 8'h0A);
        wr(4'd0, 8'hFF);
        rd(4'd0, v); chk("R4 lock kept", v, 8'h0A);
        chip_reset();
        rd(4'd0, v); chk("R4 chip clears", v, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        wr(4'd0, 8'h2A);
        cycle(1, 3'b011, 1, 0, 1, 4'd1, 8'h02);
        chk("R10 stop wins", {5'd0, power_mode}, 8'd6);
        rd(4'd1, v); chk("R10 run write dropped", v, 8'h00);
        wake();
        cycle(0, 3'd0, 1, 0, 1, 4'd1, 8'h02);
        chk("R10 wait over run", {5'd0, power_mode}, 8'd2);
        wake();
        chk("R10 wake after wait", {5'd0, power_mode}, 8'd0);
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_vlpr_blocked();
        t_write_once();
        t_vlp_modes();
        t_stop_perm();
        t_warm_reset();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule